// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers interrupt requests for a small 8-bit processor and picks the most urgent pending one. It then offers the processor a pair of vector byte addresses. The processor reads the handler pointer from those two addresses. There are seventeen fixed priority levels, and each level has its own two-byte vector slot. Sources arrive in three forms:

- seven edge-triggered pins, each with its own polarity;
- a wake-up condition taken from a multi-line key port;
- single-cycle event pulses from the on-chip peripherals and a software break strobe.

Some slots are shared between two sources, and a mode bit chooses which source owns the slot. Every level keeps a sticky pending flag. A level drives the processor request only when its enable bit is set, unless the level is non-maskable. Once the block offers a level, that choice stays frozen until the processor acknowledges it. The acknowledge also clears the flag of the level that was taken.

Top module: `irqVectorCtrl`

## Requirements
- R1: While reset is held, cpuReq is 0. On the first clock edge after reset is released, level 1 is requested with vecHi 16'hFFFD and vecLo 16'hFFFC, whatever intEn holds.
- R2: While cpuReq is 1 for level L (1..17), srcLvl equals L, vecLo equals 16'hFFFC minus 2*(L-1), and vecHi equals vecLo plus 1. While cpuReq is 0, srcLvl, vecLo and vecHi are all 0.
- R3: When several enabled levels are pending, the level with the smallest number is offered first.
- R4: Bit L-1 of intEn enables level L. A pending level that is not enabled never raises cpuReq. Levels 1 and 17 ignore intEn.
- R5: From the cycle cpuReq rises until the cycle it is acknowledged, srcLvl and the vectors do not change, even if a higher-priority level becomes pending.
- R6: An acknowledge (cpuAck high while cpuReq is high) drops cpuReq after one edge and clears that level's pending flag. An acknowledge while cpuReq is 0 has no effect.
- R7: The pins on pinIn pass through two synchronizing flops. They are assigned as INT0..INT4 on bits 0..4 (levels 2, 3, 13, 14, 15) and CNTR0/CNTR1 on bits 5/6 (levels 10, 11). A pin whose pinPol bit is 1 triggers on a rising edge; when the bit is 0 it triggers on a falling edge. Changing pinPol alone never creates a request.
- R8: modeSel bits select the owner of each shared slot:
  - bit0: level 2 (0 = INT0, 1 = input-buffer-full, periphEv bit0);
  - bit1: level 3 (0 = INT1, 1 = output-buffer-empty, periphEv bit1);
  - bit2: level 13 (0 = INT2, 1 = I2C done, periphEv bit9);
  - bit3: level 14 (0 = INT3, 1 = I2C done).
  The source that is not selected is ignored.
- R9: The key wake event is a falling edge of the AND of all synchronized keyPort lines. With modeSel bit4 at 0 it goes to level 12, and level 16 takes the A-D done pulse (periphEv bit10). With bit4 at 1 it goes to level 16, and level 12 takes the serial-2 done pulse (periphEv bit8).
- R10: A pending flag stays set until it is acknowledged or cleared through swClr (bit L-1). Repeated events while a flag is set leave a single request. An event in the same cycle as a clear leaves the flag set.
- R11: Fixed-slot pulses map as follows:
  - periphEv bits 2 and 3 (serial-1 receive and transmit) go to levels 4 and 5;
  - bits 4..7 (timers X, Y, 1, 2) go to levels 6..9;
  - brkStrobe goes to the non-maskable level 17 (vectors 16'hFFDD/16'hFFDC).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | 7 | External interrupt pins (asynchronous) |
| pinPol | input | 7 | Per-pin active edge, 1 = rising |
| keyPort | input | KEY_W | Key port input lines (asynchronous) |
| periphEv | input | 11 | Single-cycle peripheral event pulses |
| brkStrobe | input | 1 | Break instruction executed |
| modeSel | input | 5 | Shared-slot owner selects |
| intEn | input | 17 | Per-level enable |
| swClr | input | 17 | Per-level software clear of pending |
| cpuAck | input | 1 | Processor takes the offered request |
| cpuReq | output | 1 | Request to the processor |
| vecHi | output | 16 | Address of the handler high byte |
| vecLo | output | 16 | Address of the handler low byte |
| srcLvl | output | 5 | Offered level number, 0 when idle |

## Verification
The assertions assume three things about the inputs:
- the processor asserts cpuAck only as a single-cycle pulse;
- swClr and the acknowledge are the only ways software removes a pending flag;
- peripheral events arrive as one-cycle pulses aligned to the clock.

The stimulus drives every input at the falling edge. It holds each pin or key level for many cycles before changing it again, so the synchronizers never see a glitch. Every acknowledge is one cycle long and is given only after a request has been seen.

// File: rtl/irqvec_pkg.sv
package irqvec_pkg;
  localparam int NUM_LVL = 17;
  localparam int LVL_W   = $clog2(NUM_LVL + 1);
  localparam int PIN_N   = 7;
  localparam int EV_N    = 11;
  localparam int SEL_N   = 5;
  localparam int VEC_W   = 16;

  // periphEv bit positions
  localparam int EV_IBF  = 0;
  localparam int EV_OBE  = 1;
  localparam int EV_RX1  = 2;
  localparam int EV_TX1  = 3;
  localparam int EV_TMX  = 4;
  localparam int EV_TMY  = 5;
  localparam int EV_TM1  = 6;
  localparam int EV_TM2  = 7;
  localparam int EV_SIO2 = 8;
  localparam int EV_I2C  = 9;
  localparam int EV_ADC  = 10;

  // non-maskable levels: reset (index 0) and break (last index)
  localparam logic [NUM_LVL-1:0] NMI_MASK = NUM_LVL'(1) | (NUM_LVL'(1) << (NUM_LVL - 1));

  typedef struct packed {
    logic             clrValid;
    logic [LVL_W-1:0] clrIdx;
  } ackStrobe_t;
endpackage

// File: rtl/irqvec_datapath.sv
module irqvec_datapath
  import irqvec_pkg::*;
#(
  parameter int KEY_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PIN_N-1:0]   pinIn,
  input  logic [PIN_N-1:0]   pinPol,
  input  logic [KEY_W-1:0]   keyPort,
  input  logic [EV_N-1:0]    periphEv,
  input  logic               brkStrobe,
  input  logic [SEL_N-1:0]   modeSel,
  input  logic [NUM_LVL-1:0] swClr,
  input  ackStrobe_t         strobe,
  output logic [NUM_LVL-1:0] pendOut
);
  logic [PIN_N-1:0]   pinS1, pinS2, pinPrev;
  logic [PIN_N-1:0]   pinEv;
  logic [KEY_W-1:0]   keyS1, keyS2;
  logic               keyAndPrev, keyEv;
  logic [NUM_LVL-1:0] lvlEv, clrMask, pend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinS1      <= '0;
      pinS2      <= '0;
      pinPrev    <= '0;
      keyS1      <= '0;
      keyS2      <= '0;
      keyAndPrev <= 1'b0;
    end else begin
      pinS1      <= pinIn;
      pinS2      <= pinS1;
      pinPrev    <= pinS2;
      keyS1      <= keyPort;
      keyS2      <= keyS1;
      keyAndPrev <= &keyS2;
    end
  end

  // edge taken from the level history only, so a polarity flip cannot fake an edge
  for (genvar p = 0; p < PIN_N; p++) begin : gPinEdge
    assign pinEv[p] = pinPol[p] ? (pinS2[p] & ~pinPrev[p]) : (~pinS2[p] & pinPrev[p]);
  end

  assign keyEv = keyAndPrev & ~(&keyS2);

  always_comb begin
    lvlEv     = '0;
    lvlEv[1]  = modeSel[0] ? periphEv[EV_IBF] : pinEv[0];
    lvlEv[2]  = modeSel[1] ? periphEv[EV_OBE] : pinEv[1];
    lvlEv[3]  = periphEv[EV_RX1];
    lvlEv[4]  = periphEv[EV_TX1];
    lvlEv[5]  = periphEv[EV_TMX];
    lvlEv[6]  = periphEv[EV_TMY];
    lvlEv[7]  = periphEv[EV_TM1];
    lvlEv[8]  = periphEv[EV_TM2];
    lvlEv[9]  = pinEv[5];
    lvlEv[10] = pinEv[6];
    lvlEv[11] = modeSel[4] ? periphEv[EV_SIO2] : keyEv;
    lvlEv[12] = modeSel[2] ? periphEv[EV_I2C] : pinEv[2];
    lvlEv[13] = modeSel[3] ? periphEv[EV_I2C] : pinEv[3];
    lvlEv[14] = pinEv[4];
    lvlEv[15] = modeSel[4] ? keyEv : periphEv[EV_ADC];
    lvlEv[16] = brkStrobe;
  end

  assign clrMask = strobe.clrValid ? (NUM_LVL'(1) << strobe.clrIdx) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pend <= NUM_LVL'(1);
    else       pend <= (pend & ~clrMask & ~swClr) | lvlEv;
  end

  assign pendOut = pend;

  for (genvar l = 0; l < NUM_LVL; l++) begin : gPendChk
    assert_pend_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
      $fell(pend[l]) |-> $past((strobe.clrValid && strobe.clrIdx == LVL_W'(l)) || swClr[l]));
  end

  assert_rst_once_R1: assert property (@(posedge clk) disable iff (!rstN) !$rose(pend[0]));
endmodule

// File: rtl/irqvec_ctrl.sv
module irqvec_ctrl
  import irqvec_pkg::*;
#(
  parameter logic [VEC_W-1:0] VEC_TOP = 16'hFFFC
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_LVL-1:0] pend,
  input  logic [NUM_LVL-1:0] intEn,
  input  logic               cpuAck,
  output ackStrobe_t         strobe,
  output logic               cpuReq,
  output logic [VEC_W-1:0]   vecHi,
  output logic [VEC_W-1:0]   vecLo,
  output logic [LVL_W-1:0]   srcLvl
);
  logic [NUM_LVL-1:0] effReq;
  logic [LVL_W-1:0]   selIdx, heldIdx;
  logic               selAny, busy;
  logic [VEC_W-1:0]   vecOffs;

  assign effReq = pend & (intEn | NMI_MASK);

  always_comb begin
    selIdx = '0;
    selAny = 1'b0;
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (effReq[i]) begin
        selAny = 1'b1;
        selIdx = LVL_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      heldIdx <= '0;
    end else if (busy) begin
      if (cpuAck) busy <= 1'b0;
    end else if (selAny) begin
      busy    <= 1'b1;
      heldIdx <= selIdx;
    end
  end

  assign strobe.clrValid = busy & cpuAck;
  assign strobe.clrIdx   = heldIdx;

  assign vecOffs = {{(VEC_W - LVL_W - 1){1'b0}}, heldIdx, 1'b0};
  assign cpuReq  = busy;
  assign vecLo   = busy ? (VEC_TOP - vecOffs) : '0;
  assign vecHi   = busy ? (VEC_TOP - vecOffs + VEC_W'(1)) : '0;
  assign srcLvl  = busy ? (heldIdx + LVL_W'(1)) : '0;

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && !cpuAck) |=> (cpuReq && $stable(srcLvl) && $stable(vecLo)));

  assert_ack_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuAck) |=> !cpuReq);
endmodule

// File: rtl/irqVectorCtrl.sv
module irqVectorCtrl
  import irqvec_pkg::*;
#(
  parameter int KEY_W = 8,
  parameter logic [15:0] VEC_TOP = 16'hFFFC
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [6:0]         pinIn,
  input  logic [6:0]         pinPol,
  input  logic [KEY_W-1:0]   keyPort,
  input  logic [10:0]        periphEv,
  input  logic               brkStrobe,
  input  logic [4:0]         modeSel,
  input  logic [16:0]        intEn,
  input  logic [16:0]        swClr,
  input  logic               cpuAck,
  output logic               cpuReq,
  output logic [15:0]        vecHi,
  output logic [15:0]        vecLo,
  output logic [4:0]         srcLvl
);
  ackStrobe_t         strobe;
  logic [NUM_LVL-1:0] pend;

  irqvec_datapath #(.KEY_W(KEY_W)) dp_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinPol(pinPol), .keyPort(keyPort),
    .periphEv(periphEv), .brkStrobe(brkStrobe), .modeSel(modeSel), .swClr(swClr),
    .strobe(strobe), .pendOut(pend)
  );

  irqvec_ctrl #(.VEC_TOP(VEC_TOP)) ctl_i (
    .clk(clk), .rstN(rstN), .pend(pend), .intEn(intEn), .cpuAck(cpuAck),
    .strobe(strobe), .cpuReq(cpuReq), .vecHi(vecHi), .vecLo(vecLo), .srcLvl(srcLvl)
  );
endmodule

// File: tb/irqVectorCtrl_tb_top.sv
module irqVectorCtrl_tb_top;
  localparam int KEY_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [6:0] pinIn = '0;
  logic [6:0] pinPol = 7'h7F;
  logic [KEY_W-1:0] keyPort = '0;
  logic [10:0] periphEv = '0;
  logic brkStrobe = 1'b0;
  logic [4:0] modeSel = '0;
  logic [16:0] intEn = '1;
  logic [16:0] swClr = '0;
  logic cpuAck = 1'b0;
  logic cpuReq;
  logic [15:0] vecHi, vecLo;
  logic [4:0] srcLvl;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  irqVectorCtrl #(.KEY_W(KEY_W)) dut_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinPol(pinPol), .keyPort(keyPort),
    .periphEv(periphEv), .brkStrobe(brkStrobe), .modeSel(modeSel), .intEn(intEn),
    .swClr(swClr), .cpuAck(cpuAck), .cpuReq(cpuReq), .vecHi(vecHi), .vecLo(vecLo),
    .srcLvl(srcLvl)
  );

  // behavioural reference model
  bit p1[7], p2[7], p3[7];
  logic [KEY_W-1:0] k1 = '0, k2 = '0;
  bit kPrev;
  bit mp[17];
  bit mBusy;
  int mHeld;

  always @(posedge clk) begin
    bit pe[7];
    bit keyEv;
    bit lev[17];
    int sel;
    if (!rstN) begin
      foreach (p1[i]) begin p1[i] = 0; p2[i] = 0; p3[i] = 0; end
      k1 = '0; k2 = '0; kPrev = 0;
      foreach (mp[i]) mp[i] = 0;
      mp[0] = 1; mBusy = 0; mHeld = 0;
    end else begin
      for (int i = 0; i < 7; i++)
        pe[i] = pinPol[i] ? (p2[i] && !p3[i]) : (!p2[i] && p3[i]);
      keyEv = kPrev && !(&k2);
      foreach (lev[i]) lev[i] = 0;
      lev[1]  = modeSel[0] ? periphEv[0] : pe[0];
      lev[2]  = modeSel[1] ? periphEv[1] : pe[1];
      for (int i = 3; i <= 8; i++) lev[i] = periphEv[i-1];
      lev[9]  = pe[5];
      lev[10] = pe[6];
      lev[11] = modeSel[4] ? periphEv[8] : keyEv;
      lev[12] = modeSel[2] ? periphEv[9] : pe[2];
      lev[13] = modeSel[3] ? periphEv[9] : pe[3];
      lev[14] = pe[4];
      lev[15] = modeSel[4] ? keyEv : periphEv[10];
      lev[16] = brkStrobe;
      sel = -1;
      for (int l = 16; l >= 0; l--)
        if (mp[l] && (intEn[l] || l == 0 || l == 16)) sel = l;
      for (int l = 0; l < 17; l++)
        mp[l] = (mp[l] && !(mBusy && cpuAck && mHeld == l) && !swClr[l]) || lev[l];
      if (mBusy) begin
        if (cpuAck) mBusy = 0;
      end else if (sel >= 0) begin
        mBusy = 1; mHeld = sel;
      end
      for (int i = 0; i < 7; i++) begin p3[i] = p2[i]; p2[i] = p1[i]; p1[i] = pinIn[i]; end
      kPrev = &k2; k2 = k1; k1 = keyPort;
    end
  end

  // every-cycle comparison against the model (R2, R3, R5, R6)
  always @(negedge clk) begin
    if (rstN) begin
      logic [15:0] eLo;
      eLo = mBusy ? 16'(16'hFFFC - 2*mHeld) : 16'h0;
      checks++;
      if (cpuReq !== mBusy || srcLvl !== (mBusy ? 5'(mHeld+1) : 5'd0) ||
          vecLo !== eLo || vecHi !== (mBusy ? 16'(eLo + 1) : 16'h0)) begin
        errors++;
        $display("FAIL R2/R3/R5/R6 model cycle %0d actual req=%0b lvl=%0d lo=%h hi=%h expected req=%0b lvl=%0d lo=%h",
                 cyc, cpuReq, srcLvl, vecLo, vecHi, mBusy, mBusy ? mHeld+1 : 0, eLo);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitReq(input string tag, input int lvl);
    for (int i = 0; i < 10 && !cpuReq; i++) @(negedge clk);
    check({tag, " req"}, cpuReq, 1);
    check({tag, " lvl"}, srcLvl, lvl);
    check({tag, " vecLo"}, vecLo, 16'hFFFC - 2*(lvl-1));
    check({tag, " vecHi"}, vecHi, 16'hFFFD - 2*(lvl-1));
  endtask

  task automatic ackIt(input string tag);
    cpuAck = 1'b1;
    @(negedge clk);
    cpuAck = 1'b0;
    check({tag, " drop after ack"}, cpuReq, 0);
  endtask

  task automatic noReq(input string tag);
    repeat (6) @(negedge clk);
    check({tag, " no request"}, cpuReq, 0);
  endtask

  task automatic pulseEv(input int b);
    periphEv[b] = 1'b1;
    @(negedge clk);
    periphEv = '0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog R6 actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state req", cpuReq, 0);
    intEn = '0;
    rstN = 1'b1;
    @(negedge clk);
    waitReq("R1 reset vector", 1);
    ackIt("R1");
    intEn = '0;
    pulseEv(4);
    noReq("R4 masked timer X");
    intEn[5] = 1'b1;
    waitReq("R4 R11 timer X enabled", 6);
    ackIt("R6");
    intEn = '1;
    periphEv[7] = 1'b1; periphEv[2] = 1'b1;
    @(negedge clk); periphEv = '0;
    waitReq("R3 lower level first", 4);
    ackIt("R3");
    waitReq("R3 then level 9", 9);
    ackIt("R3b");
    pulseEv(7);
    waitReq("R5 hold start", 9);
    pulseEv(2);
    repeat (3) @(negedge clk);
    check("R5 held level", srcLvl, 9);
    ackIt("R5");
    waitReq("R5 next", 4);
    ackIt("R5b");
    cpuAck = 1'b1; @(negedge clk); cpuAck = 1'b0;
    noReq("R6 idle ack ignored");
    pulseEv(3);
    waitReq("R6 R11 after idle ack", 5);
    ackIt("R6b");
    pinIn[4] = 1'b1;
    waitReq("R7 rising INT4", 15);
    ackIt("R7");
    pinPol[5] = 1'b0;
    pinIn[5] = 1'b1;
    noReq("R7 rise on falling-edge pin");
    pinIn[5] = 1'b0;
    waitReq("R7 falling CNTR0", 10);
    ackIt("R7b");
    pinPol[4] = 1'b0;
    noReq("R7 polarity flip alone");
    pulseEv(0);
    noReq("R8 unselected buffer-full");
    modeSel[0] = 1'b1;
    pulseEv(0);
    waitReq("R8 buffer-full on level 2", 2);
    ackIt("R8");
    modeSel[2] = 1'b1;
    pulseEv(9);
    waitReq("R8 I2C on level 13", 13);
    ackIt("R8b");
    keyPort = '1;
    noReq("R9 key rise");
    keyPort[0] = 1'b0;
    waitReq("R9 key wake level 12", 12);
    ackIt("R9");
    modeSel[4] = 1'b1;
    keyPort = '1;
    repeat (4) @(negedge clk);
    keyPort[3] = 1'b0;
    waitReq("R9 key wake level 16", 16);
    ackIt("R9b");
    pulseEv(10);
    noReq("R9 A-D ignored when key owns 16");
    intEn[6] = 1'b0;
    pulseEv(5); pulseEv(5);
    intEn[6] = 1'b1;
    waitReq("R10 single request", 7);
    ackIt("R10");
    noReq("R10 no second request");
    intEn[6] = 1'b0;
    pulseEv(5);
    swClr[6] = 1'b1; @(negedge clk); swClr = '0;
    intEn[6] = 1'b1;
    noReq("R10 software clear");
    intEn[6] = 1'b0;
    periphEv[5] = 1'b1; swClr[6] = 1'b1;
    @(negedge clk); periphEv = '0; swClr = '0;
    intEn[6] = 1'b1;
    waitReq("R10 set wins over clear", 7);
    ackIt("R10b");
    intEn = '0;
    brkStrobe = 1'b1; @(negedge clk); brkStrobe = 1'b0;
    waitReq("R11 R4 break non-maskable", 17);
    ackIt("R11");
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule